// File: doc/BRIEF.md
# Decode Stall Unit for a Pipeline Without Bypass Paths

This block sits beside the decode stage of a five-stage in-order pipeline that has no result-bypass network. Each cycle it compares the register numbers the decode-stage instruction reads against the destinations of the two older instructions that have not yet written the register file. Those are the one in execute and the one in memory. If any live match exists, it freezes the program counter and the fetch/decode register and turns the next execute-stage entry into a bubble.

The execute-stage producer arrives as two raw fields, rd and rt, plus a select bit. Register-type operations write rd; loads and immediate operations write rt. The block resolves that choice itself. The memory-stage producer arrives with its destination already resolved, so it is compared directly. The writeback stage is never compared, because the register file writes early in the cycle and reads late.

The decision is one combinational verdict with four values. FLOW means no match. HOLD_EX means only the execute stage matches. HOLD_MEM means only the memory stage matches. HOLD_BOTH means both match. FLOW enables both writes and clears the bubble control; the three HOLD verdicts freeze and insert a bubble. The verdict has no memory: the inserted bubble carries a cleared write enable, so the stall releases by itself as the producer moves down the pipe. A consumer directly behind its producer is therefore held for two cycles.

Top module: `hazard_stall_unit`

## Requirements
- R1: A read source (source A with id_reads_a=1, or source B with id_reads_b=1) equal to the execute-stage destination, with ex_wr_en=1 and that destination non-zero, drives pc_we=0.
- R2: The execute-stage destination is ex_rd when ex_dst_is_rd=1 and ex_rt when ex_dst_is_rd=0. The unselected field never causes a stall.
- R3: A read source equal to mem_dst, with mem_wr_en=1 and mem_dst non-zero, drives pc_we=0.
- R4: Register number 0 never causes a stall, whether it is the source or the destination.
- R5: A producer whose write enable (ex_wr_en or mem_wr_en) is 0 never causes a stall.
- R6: A source whose read flag is 0 never causes a stall. This covers rt for immediate ALU operations and loads. A store sets id_reads_b=1 and is held on an rt match.
- R7: ifid_we always equals pc_we, and idex_flush always equals the inverse of pc_we.
- R8: With no live match in either stage, pc_we=1.
- R9: A consumer directly behind its producer, with a bubble entering execute on each stall, sees pc_we low for exactly two cycles and high on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_W | First source register number of the decode-stage instruction |
| id_src_b | input | REG_W | Second source register number (rt) of the decode-stage instruction |
| id_reads_a | input | 1 | Decode instruction really reads source A |
| id_reads_b | input | 1 | Decode instruction really reads source B (set for register ops and stores) |
| ex_rt | input | REG_W | rt field held in the decode/execute register |
| ex_rd | input | REG_W | rd field held in the decode/execute register |
| ex_dst_is_rd | input | 1 | Execute instruction writes rd (1) or rt (0) |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| mem_dst | input | REG_W | Resolved destination held in the execute/memory register |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| pc_we | output | 1 | Program counter may advance |
| ifid_we | output | 1 | Fetch/decode register may load |
| idex_flush | output | 1 | Zero the control fields entering execute (bubble) |

## Verification
The hardest case to reach is one where the two producer stages and the unused execute field all point at the same register, but only one of them is live. That case alone separates a correct destination mux, and correct enable and read-flag gating, from designs that merely look right. The bench sweeps every combination of four register numbers (including 0) across all five register inputs, together with every setting of the five flag inputs. Every aliasing pattern of this kind is therefore driven. A short directed sequence then replays a dependent pair advancing through the pipe with bubbles, to show the two-cycle hold.

// File: rtl/hsu_pkg.sv
package hsu_pkg;

    // Outcome of one cycle's dependence check
    typedef enum logic [1:0] {
        VD_FLOW      = 2'd0,
        VD_HOLD_EX   = 2'd1,
        VD_HOLD_MEM  = 2'd2,
        VD_HOLD_BOTH = 2'd3
    } verdict_t;

    // Number of source operands a decode-stage instruction may read
    localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/hsu_dest_sel.sv
module hsu_dest_sel #(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] rt_field,
    input  logic [REG_W-1:0] rd_field,
    input  logic             pick_rd,
    output logic [REG_W-1:0] dst
);

    // Register ops write rd; loads and immediate ops write rt
    always_comb begin
        dst = pick_rd ? rd_field : rt_field;
    end

endmodule

// File: rtl/hsu_src_match.sv
module hsu_src_match #(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             src_read,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wr,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    output logic             hit_ex,
    output logic             hit_mem
);

    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic src_live;

    // Register 0 is hard-wired, so it can never carry a dependence
    always_comb begin
        src_live = src_read && (src != ZERO_REG);
        hit_ex   = src_live && ex_wr  && (ex_dst  == src);
        hit_mem  = src_live && mem_wr && (mem_dst == src);
    end

endmodule

// File: rtl/hsu_verdict.sv
module hsu_verdict
    import hsu_pkg::*;
(
    input  logic     any_ex,
    input  logic     any_mem,
    output verdict_t verdict,
    output logic     pc_we,
    output logic     ifid_we,
    output logic     idex_flush
);

    always_comb begin
        unique case ({any_mem, any_ex})
            2'b00:   verdict = VD_FLOW;
            2'b01:   verdict = VD_HOLD_EX;
            2'b10:   verdict = VD_HOLD_MEM;
            default: verdict = VD_HOLD_BOTH;
        endcase
    end

    always_comb begin
        unique case (verdict)
            VD_FLOW: begin
                pc_we      = 1'b1;
                ifid_we    = 1'b1;
                idex_flush = 1'b0;
            end
            VD_HOLD_EX, VD_HOLD_MEM, VD_HOLD_BOTH: begin
                pc_we      = 1'b0;
                ifid_we    = 1'b0;
                idex_flush = 1'b1;
            end
            default: begin
                pc_we      = 1'b0;
                ifid_we    = 1'b0;
                idex_flush = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
    import hsu_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic             id_reads_a,
    input  logic             id_reads_b,
    input  logic [REG_W-1:0] ex_rt,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_dst_is_rd,
    input  logic             ex_wr_en,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr_en,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             idex_flush
);

    logic [REG_W-1:0]               ex_dst;
    logic [NUM_SRC-1:0][REG_W-1:0]  src_num;
    logic [NUM_SRC-1:0]             src_rd;
    logic [NUM_SRC-1:0]             hit_ex_v;
    logic [NUM_SRC-1:0]             hit_mem_v;
    verdict_t                       verdict;

    assign src_num[0] = id_src_a;
    assign src_num[1] = id_src_b;
    assign src_rd[0]  = id_reads_a;
    assign src_rd[1]  = id_reads_b;

    hsu_dest_sel #(.REG_W(REG_W)) u_dsel (
        .rt_field (ex_rt),
        .rd_field (ex_rd),
        .pick_rd  (ex_dst_is_rd),
        .dst      (ex_dst)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        hsu_src_match #(.REG_W(REG_W)) u_match (
            .src      (src_num[s]),
            .src_read (src_rd[s]),
            .ex_dst   (ex_dst),
            .ex_wr    (ex_wr_en),
            .mem_dst  (mem_dst),
            .mem_wr   (mem_wr_en),
            .hit_ex   (hit_ex_v[s]),
            .hit_mem  (hit_mem_v[s])
        );
    end

    hsu_verdict u_vd (
        .any_ex     (|hit_ex_v),
        .any_mem    (|hit_mem_v),
        .verdict    (verdict),
        .pc_we      (pc_we),
        .ifid_we    (ifid_we),
        .idex_flush (idex_flush)
    );

endmodule

// File: rtl/hsu_checks.sv
module hsu_checks #(
    parameter int unsigned REG_W = 5
) (
    input logic [REG_W-1:0] id_src_a,
    input logic [REG_W-1:0] id_src_b,
    input logic             id_reads_a,
    input logic             id_reads_b,
    input logic [REG_W-1:0] ex_rt,
    input logic [REG_W-1:0] ex_rd,
    input logic             ex_dst_is_rd,
    input logic             ex_wr_en,
    input logic [REG_W-1:0] mem_dst,
    input logic             mem_wr_en,
    input logic             pc_we,
    input logic             ifid_we,
    input logic             idex_flush
);

    localparam logic [REG_W-1:0] ZR = '0;

    always_comb begin
        if (!$isunknown({id_src_a, id_src_b, id_reads_a, id_reads_b, ex_rt, ex_rd,
                         ex_dst_is_rd, ex_wr_en, mem_dst, mem_wr_en,
                         pc_we, ifid_we, idex_flush})) begin
            // R1
            ex_rd_hit_chk: assert (!(ex_wr_en && ex_dst_is_rd && ex_rd != ZR &&
                                     id_reads_a && id_src_a == ex_rd) || !pc_we)
                else $error("execute rd dependence not held");
            // R2
            ex_rt_hit_chk: assert (!(ex_wr_en && !ex_dst_is_rd && ex_rt != ZR &&
                                     id_reads_b && id_src_b == ex_rt) || !pc_we)
                else $error("execute rt dependence not held");
            // R3
            mem_hit_chk: assert (!(mem_wr_en && mem_dst != ZR &&
                                   id_reads_a && id_src_a == mem_dst) || !pc_we)
                else $error("memory-stage dependence not held");
            // R4
            zero_src_chk: assert (!((id_src_a == ZR || !id_reads_a) &&
                                    (id_src_b == ZR || !id_reads_b)) || pc_we)
                else $error("stall with no live source");
            // R5
            no_writer_chk: assert ((ex_wr_en || mem_wr_en) || pc_we)
                else $error("stall with no writing producer");
            // R7
            ifid_mirror_chk: assert (ifid_we == pc_we)
                else $error("fetch/decode enable differs from pc enable");
            // R7
            bubble_inverse_chk: assert (idex_flush != pc_we)
                else $error("bubble control not inverse of pc enable");
        end
    end

endmodule

bind hazard_stall_unit hsu_checks #(.REG_W(REG_W)) u_chk (
    .id_src_a     (id_src_a),
    .id_src_b     (id_src_b),
    .id_reads_a   (id_reads_a),
    .id_reads_b   (id_reads_b),
    .ex_rt        (ex_rt),
    .ex_rd        (ex_rd),
    .ex_dst_is_rd (ex_dst_is_rd),
    .ex_wr_en     (ex_wr_en),
    .mem_dst      (mem_dst),
    .mem_wr_en    (mem_wr_en),
    .pc_we        (pc_we),
    .ifid_we      (ifid_we),
    .idex_flush   (idex_flush)
);

// File: tb/sim_hazard_stall_unit.sv
`timescale 1ns/1ps
module sim_hazard_stall_unit;

    localparam int unsigned RW = 5;

    logic          clk = 1'b0;
    logic [RW-1:0] id_src_a, id_src_b, ex_rt, ex_rd, mem_dst;
    logic          id_reads_a, id_reads_b, ex_dst_is_rd, ex_wr_en, mem_wr_en;
    logic          pc_we, ifid_we, idex_flush;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hazard_stall_unit #(.REG_W(RW)) u0 (
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .id_reads_a(id_reads_a), .id_reads_b(id_reads_b),
        .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_dst_is_rd(ex_dst_is_rd), .ex_wr_en(ex_wr_en),
        .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_flush(idex_flush)
    );

    task automatic drive(input logic [RW-1:0] sa, input logic [RW-1:0] sb,
                         input logic ra, input logic rb,
                         input logic [RW-1:0] ert, input logic [RW-1:0] erd,
                         input logic pick, input logic ew,
                         input logic [RW-1:0] md, input logic mw);
        @(posedge clk);
        id_src_a = sa; id_src_b = sb; id_reads_a = ra; id_reads_b = rb;
        ex_rt = ert; ex_rd = erd; ex_dst_is_rd = pick; ex_wr_en = ew;
        mem_dst = md; mem_wr_en = mw;
        @(negedge clk);
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Quiet state: nothing writes, nothing read (R8)
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check_bit("R8 idle pc_we", pc_we, 1'b1);
        check_bit("R7 idle flush", idex_flush, 1'b0);

        // Directed: R2 unselected field ignored
        drive(3, 0, 1, 0, 3, 5, 1, 1, 0, 0);
        check_bit("R2 rt ignored when rd picked", pc_we, 1'b1);
        drive(3, 0, 1, 0, 3, 5, 0, 1, 0, 0);
        check_bit("R2 rt picked", pc_we, 1'b0);
        // R4 register 0
        drive(0, 0, 1, 1, 0, 0, 0, 1, 0, 1);
        check_bit("R4 zero register", pc_we, 1'b1);
        // R5 write enables off
        drive(4, 4, 1, 1, 4, 4, 1, 0, 4, 0);
        check_bit("R5 no writer", pc_we, 1'b1);
        // R6 immediate op does not read rt; store does
        drive(1, 6, 1, 0, 6, 0, 0, 1, 0, 0);
        check_bit("R6 unread rt", pc_we, 1'b1);
        drive(1, 6, 1, 1, 6, 0, 0, 1, 0, 0);
        check_bit("R6 store reads rt", pc_we, 1'b0);

        // R9: producer writes r1 via rd, consumer reads r1 right behind it
        drive(1, 2, 1, 1, 0, 1, 1, 1, 0, 0);
        check_bit("R9 hold cycle 1", pc_we, 1'b0);
        drive(1, 2, 1, 1, 0, 0, 0, 0, 1, 1);   // bubble in execute, producer in memory
        check_bit("R9 hold cycle 2", pc_we, 1'b0);
        drive(1, 2, 1, 1, 0, 0, 0, 0, 0, 0);   // producer in writeback: not compared
        check_bit("R9 release cycle 3", pc_we, 1'b1);

        // Sweep: registers 0..3 on every field, all flag settings
        for (int f = 0; f < 32; f++) begin
            for (int v = 0; v < 1024; v++) begin
                logic [RW-1:0] sa, sb, ert, erd, md, edst;
                logic ra, rb, pk, ew, mw, hex, hmem, exp_we;
                string tag;
                sa  = RW'(v & 3);        sb  = RW'((v >> 2) & 3);
                ert = RW'((v >> 4) & 3); erd = RW'((v >> 6) & 3);
                md  = RW'((v >> 8) & 3);
                ra = f[0]; rb = f[1]; pk = f[2]; ew = f[3]; mw = f[4];
                edst = pk ? erd : ert;
                hex  = ew && edst != 0 &&
                       ((ra && sa == edst) || (rb && sb == edst));
                hmem = mw && md != 0 &&
                       ((ra && sa == md) || (rb && sb == md));
                exp_we = !(hex || hmem);
                if (hex)       tag = "R1 sweep";
                else if (hmem) tag = "R3 sweep";
                else           tag = "R8 sweep";
                drive(sa, sb, ra, rb, ert, erd, pk, ew, md, mw);
                check_bit(tag, pc_we, exp_we);
                check_bit("R7 sweep mirror", ifid_we, pc_we);
                check_bit("R7 sweep bubble", idex_flush, ~pc_we);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule